// File: doc/BRIEF.md
# Receive Descriptor Ring Fill Engine

This block is the hardware producer for a circular ring of receive descriptors kept in on-chip storage. Each ring entry carries a 4-bit ownership code, a stored length, a truncation flag and an abstract buffer tag, taken here as the first byte of the frame. Frames come in as a byte stream and first land in a small local staging store. From there the engine moves them one at a time into the entry under its current pointer. It marks that entry as holding a frame and steps the pointer forward by one, wrapping at the end of the ring.

Software owns the other side of the ring through a simple register port. It can read and write any ring entry, read the current and next pointers, clear sticky interrupt bits and restart the engine after a stall. If the entry under the pointer is not marked empty when a frame is waiting, the engine stops and flags an error. Frames keep collecting in the staging store while the engine is stopped. When that store fills, a separate interrupt is raised. Frames that end while the store is full are discarded and counted.

After a restart the engine does not go back to the entry it stopped on. It resumes at the following entry, even if software has since made the stopped-on entry empty again. Software has to allow for this skipped slot.

Top module: `rxr_fill_engine`

## Requirements
- R1: After reset every ring entry reads 0x0000000A (code 0xA = empty), the current pointer is 0, the next pointer is 1, all interrupt bits are 0 and the engine is not stalled.
- R2: A staged frame is written to the entry at the current pointer with code 0x4 in bits [3:0], the first byte in bits [15:8] and the length in bits [31:16]. The current pointer then advances by exactly one, from RING_DEPTH-1 back to 0, and the next pointer always equals the current pointer plus one modulo RING_DEPTH.
- R3: When a frame is waiting and the entry at the current pointer does not hold code 0xA, that entry is left untouched, the pointer holds, the engine stalls (control register bit 0 reads 1) and interrupt bits 2 (stall) and 1 (error summary) are set.
- R4: The staging store holds STAGE_SLOTS frames, including while stalled. The frame that fills it sets interrupt bit 3 (store full) and bit 1. A frame that ends while the store is full is discarded, and the saturating discard count (register 3) increases by one.
- R5: Writing 1 to control register bit 0 while stalled clears the stall and moves the current pointer to the entry after the stalled-on one. This holds even if that entry has since been made empty. Staged frames are then stored in arrival order.
- R6: `frame_pulse` is high for exactly one cycle for each entry marked 0x4, and each such fill sets interrupt bit 0.
- R7: Interrupt bits stay set until software writes 1 to them at register 0; a written 0 leaves a bit unchanged.
- R8: A frame longer than BUF_CAP bytes is stored with length BUF_CAP and bit 4 set, and is still marked 0x4; frames of BUF_CAP bytes or fewer have bit 4 clear.
- R9: Address bit 8 = 0 selects ring entry address[7:0] for reads and whole-word writes. A host write to an entry takes priority over the engine, which waits that cycle.
- R10: A restart write while the engine is not stalled has no effect on the pointer or the stall state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input byte valid |
| s_data | input | 8 | Input byte |
| s_last | input | 1 | Marks the final byte of a frame |
| s_ready | output | 1 | Always 1; overflow frames are discarded and counted instead |
| host_addr | input | PTR_W+1 | Bit PTR_W = 1 selects registers (0 irq, 1 control, 2 pointers, 3 discards), otherwise a ring entry |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational read data; pointer register has current in [15:0], next in [31:16] |
| irq_status | output | 4 | Sticky bits: 0 fill, 1 error summary, 2 stall, 3 store full |
| frame_pulse | output | 1 | One-cycle pulse per filled entry |
| cur_ptr | output | PTR_W | Current fill pointer |
| next_ptr | output | PTR_W | Current pointer plus one, modulo ring size |
| halted | output | 1 | Engine stalled |

## Verification
The bench goes after the stall-and-skip sequence. A design that retried the stalled-on slot after restart would put the first staged frame in entry 8 instead of 9, and every later frame one slot early. It fills the staging store while stalled and pushes two more frames. A design off by one on the store depth would either raise the store-full bit late or store a frame that should have been discarded, which shows in the discard count and in entry 13. It also checks lengths one below, at and above the capacity, where an off-by-one truncation compare would set bit 4 on a 64-byte frame. Finally it drives the pointer across the end of the ring, where a missed wrap would leave the pointer at 256 aliasing or fail to stall on the still-full entry 0.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam logic [3:0] DST_EMPTY = 4'hA;
   localparam logic [3:0] DST_FULL  = 4'h4;
   localparam logic [3:0] DST_IDLE  = 4'hF;

   localparam int IRQ_W     = 4;
   localparam int IRQ_FILL  = 0;
   localparam int IRQ_ERR   = 1;
   localparam int IRQ_STALL = 2;
   localparam int IRQ_LFULL = 3;

   localparam logic [1:0] REG_IRQ  = 2'd0;
   localparam logic [1:0] REG_CTRL = 2'd1;
   localparam logic [1:0] REG_PTR  = 2'd2;
   localparam logic [1:0] REG_DROP = 2'd3;

   localparam logic [31:0] DESC_RST = {28'd0, DST_EMPTY};

   function automatic logic [31:0] pack_desc(input logic [3:0] st, input logic trunc,
                                             input logic [7:0] tag, input logic [15:0] len);
      return {len, tag, 3'b000, trunc, st};
   endfunction
endpackage

// File: rtl/rxr_frame_stager.sv
module rxr_frame_stager #(
   parameter int unsigned BUF_CAP     = 64,
   parameter int unsigned STAGE_SLOTS = 4,
   parameter int unsigned DROP_W      = 8,
   localparam int unsigned LEN_W  = $clog2(BUF_CAP + 2),
   localparam int unsigned SLOT_W = $clog2(STAGE_SLOTS),
   localparam int unsigned FILL_W = $clog2(STAGE_SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   input  logic [7:0]        s_data,
   input  logic              s_last,
   input  logic              pop,
   output logic              rec_valid,
   output logic [LEN_W-1:0]  rec_len,
   output logic [7:0]        rec_tag,
   output logic              rec_trunc,
   output logic              full_evt,
   output logic [DROP_W-1:0] drop_cnt
);
   localparam logic [LEN_W-1:0]  CAP_L  = LEN_W'(BUF_CAP);
   localparam logic [LEN_W-1:0]  SAT_L  = LEN_W'(BUF_CAP + 1);
   localparam logic [FILL_W-1:0] TOP_F  = FILL_W'(STAGE_SLOTS);
   localparam logic [FILL_W-1:0] NEAR_F = FILL_W'(STAGE_SLOTS - 1);
   localparam int unsigned REC_W = LEN_W + 9;

   logic [LEN_W-1:0]  beat_cnt, cnt_inc, len_cap;
   logic [7:0]        tag_q, tag_now;
   logic              over, frame_end, push, is_full, do_pop;
   logic [REC_W-1:0]  slot_mem [STAGE_SLOTS];
   logic [SLOT_W-1:0] wr_ix, rd_ix, wr_nx, rd_nx;
   logic [FILL_W-1:0] fill;

   // ring index stepping: free wrap for powers of two, compare otherwise
   if ((STAGE_SLOTS & (STAGE_SLOTS - 1)) == 0) begin : g_pow2_wrap
      assign wr_nx = wr_ix + 1'b1;
      assign rd_nx = rd_ix + 1'b1;
   end else begin : g_cmp_wrap
      assign wr_nx = (wr_ix == SLOT_W'(STAGE_SLOTS - 1)) ? '0 : wr_ix + 1'b1;
      assign rd_nx = (rd_ix == SLOT_W'(STAGE_SLOTS - 1)) ? '0 : rd_ix + 1'b1;
   end

   always_comb begin
      cnt_inc   = (beat_cnt == SAT_L) ? beat_cnt : beat_cnt + 1'b1;
      over      = cnt_inc > CAP_L;
      len_cap   = over ? CAP_L : cnt_inc;
      tag_now   = (beat_cnt == '0) ? s_data : tag_q;
      frame_end = s_valid && s_last;
      is_full   = (fill == TOP_F);
      push      = frame_end && !is_full;
      do_pop    = pop && rec_valid;
   end

   assign rec_valid = (fill != '0);
   assign {rec_trunc, rec_tag, rec_len} = slot_mem[rd_ix];
   assign full_evt  = push && !do_pop && (fill == NEAR_F);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_cnt <= '0;
         tag_q    <= '0;
         wr_ix    <= '0;
         rd_ix    <= '0;
         fill     <= '0;
         drop_cnt <= '0;
      end else begin
         if (s_valid) begin
            beat_cnt <= s_last ? '0 : cnt_inc;
            if (beat_cnt == '0) tag_q <= s_data;
         end
         if (push) wr_ix <= wr_nx;
         if (do_pop) rd_ix <= rd_nx;
         if (push && !do_pop)      fill <= fill + 1'b1;
         else if (!push && do_pop) fill <= fill - 1'b1;
         if (frame_end && is_full && (drop_cnt != '1)) drop_cnt <= drop_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) slot_mem[wr_ix] <= {over, tag_now, len_cap};
   end

   // R4: a frame ending on a full store is counted as discarded
   p_drop_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && is_full && (drop_cnt != '1)) |=> (drop_cnt == $past(drop_cnt) + 1'b1));
   // R4: occupancy never exceeds the slot count
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= TOP_F);
   p_full_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
      full_evt |=> is_full);
endmodule

// File: rtl/rxr_desc_ram.sv
module rxr_desc_ram #(
   parameter int unsigned ENTRIES = 256,
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned STAT_W  = 4,
   parameter logic [WORD_W-1:0] RST_WORD = '0,
   localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [IDX_W-1:0]  host_idx,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_rdata,
   input  logic              eng_we,
   input  logic [IDX_W-1:0]  eng_idx,
   input  logic [WORD_W-1:0] eng_wdata,
   output logic [STAT_W-1:0] eng_rstat
);
   logic [WORD_W-1:0] mem [ENTRIES];

   assign host_rdata = mem[host_idx];
   assign eng_rstat  = mem[eng_idx][STAT_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) mem[i] <= RST_WORD;
      end else if (host_we) begin
         mem[host_idx] <= host_wdata;
      end else if (eng_we) begin
         mem[eng_idx] <= eng_wdata;
      end
   end

   // R9: the engine never writes in a cycle the host owns
   p_single_writer_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_we && eng_we));
   // R2: an engine write lands the new word
   p_eng_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_we |=> (mem[$past(eng_idx)] == $past(eng_wdata)));
endmodule

// File: rtl/rxr_irq_bank.sv
module rxr_irq_bank #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] status_o
);
   for (genvar b = 0; b < N; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)        status_o[b] <= 1'b0;
         else if (set_i[b]) status_o[b] <= 1'b1;
         else if (clr_i[b]) status_o[b] <= 1'b0;
      end
      // R7: sticky until written with one
      p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (status_o[b] && !clr_i[b]) |=> status_o[b]);
      p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[b] && !set_i[b]) |=> !status_o[b]);
   end
endmodule

// File: rtl/rxr_fill_engine.sv
module rxr_fill_engine
   import rxr_pkg::*;
#(
   parameter int unsigned RING_DEPTH  = 256,
   parameter int unsigned BUF_CAP     = 64,
   parameter int unsigned STAGE_SLOTS = 4,
   parameter int unsigned DROP_W      = 8,
   localparam int unsigned PTR_W = $clog2(RING_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s_valid,
   input  logic [7:0]       s_data,
   input  logic             s_last,
   output logic             s_ready,
   input  logic [PTR_W:0]   host_addr,
   input  logic             host_wr,
   input  logic [31:0]      host_wdata,
   output logic [31:0]      host_rdata,
   output logic [IRQ_W-1:0] irq_status,
   output logic             frame_pulse,
   output logic [PTR_W-1:0] cur_ptr,
   output logic [PTR_W-1:0] next_ptr,
   output logic             halted
);
   localparam int unsigned LEN_W = $clog2(BUF_CAP + 2);
   localparam logic [PTR_W-1:0] LAST_IX = PTR_W'(RING_DEPTH - 1);

   if (RING_DEPTH < 4 || RING_DEPTH > 65536) begin : g_bad_ring
      $error("RING_DEPTH must be within 4..65536");
   end
   if (BUF_CAP < 1 || BUF_CAP > 65534) begin : g_bad_cap
      $error("BUF_CAP must be within 1..65534");
   end
   if (STAGE_SLOTS < 2) begin : g_bad_slots
      $error("STAGE_SLOTS must be at least 2");
   end
   if (DROP_W < 1 || DROP_W > 32) begin : g_bad_drop
      $error("DROP_W must be within 1..32");
   end

   logic              host_is_reg, host_desc_we, restart_req;
   logic [1:0]        reg_sel;
   logic [PTR_W-1:0]  host_idx, cur_q;
   logic [IRQ_W-1:0]  irq_set, irq_clr;
   logic              rec_valid, rec_trunc, full_evt;
   logic [LEN_W-1:0]  rec_len;
   logic [7:0]        rec_tag;
   logic [DROP_W-1:0] drop_cnt;
   logic [3:0]        cur_st;
   logic [31:0]       ram_hrd, eng_wdata;
   logic              fill_try, eng_we, stall_evt, halted_q, pulse_q;

   assign s_ready      = 1'b1;
   assign host_is_reg  = host_addr[PTR_W];
   assign host_idx     = host_addr[PTR_W-1:0];
   assign reg_sel      = host_addr[1:0];
   assign host_desc_we = host_wr && !host_is_reg;
   assign restart_req  = host_wr && host_is_reg && (reg_sel == REG_CTRL) && host_wdata[0];
   assign irq_clr      = (host_wr && host_is_reg && (reg_sel == REG_IRQ)) ?
                         host_wdata[IRQ_W-1:0] : '0;

   rxr_frame_stager #(
      .BUF_CAP(BUF_CAP), .STAGE_SLOTS(STAGE_SLOTS), .DROP_W(DROP_W)
   ) u_stager (
      .clk(clk), .rst_n(rst_n),
      .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
      .pop(eng_we),
      .rec_valid(rec_valid), .rec_len(rec_len), .rec_tag(rec_tag), .rec_trunc(rec_trunc),
      .full_evt(full_evt), .drop_cnt(drop_cnt)
   );

   assign eng_wdata = pack_desc(DST_FULL, rec_trunc, rec_tag, 16'(rec_len));

   rxr_desc_ram #(
      .ENTRIES(RING_DEPTH), .WORD_W(32), .STAT_W(4), .RST_WORD(DESC_RST)
   ) u_ring (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_desc_we), .host_idx(host_idx), .host_wdata(host_wdata),
      .host_rdata(ram_hrd),
      .eng_we(eng_we), .eng_idx(cur_q), .eng_wdata(eng_wdata), .eng_rstat(cur_st)
   );

   // engine step: one staged frame per cycle while running and the host is off the ring
   always_comb begin
      fill_try  = rec_valid && !halted_q && !host_desc_we;
      eng_we    = fill_try && (cur_st == DST_EMPTY);
      stall_evt = fill_try && (cur_st != DST_EMPTY);
      next_ptr  = (cur_q == LAST_IX) ? '0 : cur_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q    <= '0;
         halted_q <= 1'b0;
         pulse_q  <= 1'b0;
      end else begin
         pulse_q <= eng_we;
         if (eng_we) begin
            cur_q <= next_ptr;
         end else if (stall_evt) begin
            halted_q <= 1'b1;
         end else if (halted_q && restart_req) begin
            halted_q <= 1'b0;
            cur_q    <= next_ptr;   // skip the entry that caused the stall
         end
      end
   end

   always_comb begin
      irq_set            = '0;
      irq_set[IRQ_FILL]  = eng_we;
      irq_set[IRQ_ERR]   = stall_evt || full_evt;
      irq_set[IRQ_STALL] = stall_evt;
      irq_set[IRQ_LFULL] = full_evt;
   end

   rxr_irq_bank #(.N(IRQ_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .set_i(irq_set), .clr_i(irq_clr), .status_o(irq_status)
   );

   always_comb begin
      host_rdata = ram_hrd;
      if (host_is_reg) begin
         unique case (reg_sel)
            REG_IRQ:  host_rdata = 32'(irq_status);
            REG_CTRL: host_rdata = 32'(halted_q);
            REG_PTR:  host_rdata = 32'(cur_q) | (32'(next_ptr) << 16);
            default:  host_rdata = 32'(drop_cnt);
         endcase
      end
   end

   assign cur_ptr     = cur_q;
   assign halted      = halted_q;
   assign frame_pulse = pulse_q;

   // R2: each fill moves the pointer to the old next pointer
   p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_we |=> (cur_ptr == $past(next_ptr)));
   // R3: a stalled engine neither writes nor moves until restarted
   p_no_write_stalled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !eng_we);
   p_stall_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !restart_req) |=> (halted && $stable(cur_ptr)));
   // R5: restart resumes one past the faulting entry
   p_restart_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && restart_req) |=> (!halted && (cur_ptr == $past(next_ptr))));
   // R6: a fill produces the pulse in the following cycle
   p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      eng_we |=> frame_pulse);
   // R10: restart while running changes nothing
   p_restart_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && restart_req && !eng_we) |=> $stable(cur_ptr));
endmodule

// File: tb/rxr_fill_engine_tb.sv
module rxr_fill_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_valid = 1'b0, s_last = 1'b0;
   logic [7:0]  s_data = '0;
   logic        s_ready;
   logic [8:0]  host_addr = '0;
   logic        host_wr = 1'b0;
   logic [31:0] host_wdata = '0, host_rdata;
   logic [3:0]  irq_status;
   logic        frame_pulse, halted;
   logic [7:0]  cur_ptr, next_ptr;

   int n_chk = 0, n_bad = 0, pulses = 0;
   logic [31:0] rd;

   always #4 clk = ~clk;   // 125 MHz

   rxr_fill_engine u_dut (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
      .s_ready(s_ready), .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .irq_status(irq_status), .frame_pulse(frame_pulse),
      .cur_ptr(cur_ptr), .next_ptr(next_ptr), .halted(halted)
   );

   always @(posedge clk) if (rst_n && frame_pulse) pulses++;

   // {frame length, first byte, expected entry word}
   localparam logic [55:0] VEC [6] = '{
      {16'd1,   8'h11, 32'h0001_1104},
      {16'd5,   8'h22, 32'h0005_2204},
      {16'd64,  8'h33, 32'h0040_3304},
      {16'd65,  8'h44, 32'h0040_4414},
      {16'd200, 8'h55, 32'h0040_5514},
      {16'd2,   8'h66, 32'h0002_6604}
   };

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic hwrite(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hread(input logic [8:0] a, output logic [31:0] d);
      @(negedge clk);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic send_frame(input int len, input logic [7:0] tag);
      for (int b = 0; b < len; b++) begin
         @(negedge clk);
         s_valid = 1'b1;
         s_data  = (b == 0) ? tag : 8'(b);
         s_last  = (b == len - 1);
      end
      @(negedge clk);
      s_valid = 1'b0; s_last = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      hread(9'h000, rd); chk("R1 entry 0", rd, 32'h0000_000A);
      hread(9'h080, rd); chk("R1 entry 128", rd, 32'h0000_000A);
      hread(9'h0FF, rd); chk("R1 entry 255", rd, 32'h0000_000A);
      hread(9'h102, rd); chk("R1 pointers", rd, 32'h0001_0000);
      hread(9'h100, rd); chk("R1 irq", rd, 32'h0);
      hread(9'h101, rd); chk("R1 stall", rd, 32'h0);

      // R2 / R8 vector walk
      for (int i = 0; i < 6; i++) begin
         send_frame(int'(VEC[i][55:40]), VEC[i][39:32]);
         tick(3);
         hread(9'(i), rd);
         chk($sformatf("R2/R8 entry %0d", i), rd, VEC[i][31:0]);
         chk($sformatf("R2 cur after %0d", i), 32'(cur_ptr), 32'(i + 1));
      end
      chk("R6 pulse count", 32'(pulses), 32'd6);
      hread(9'h100, rd); chk("R6 fill irq", rd, 32'h1);

      // R7 write-one-to-clear
      hwrite(9'h100, 32'h0); hread(9'h100, rd); chk("R7 zero write keeps", rd, 32'h1);
      hwrite(9'h100, 32'h1); hread(9'h100, rd); chk("R7 one write clears", rd, 32'h0);

      // R10 restart while running
      hwrite(9'h101, 32'h1); tick(2);
      chk("R10 cur unchanged", 32'(cur_ptr), 32'd6);
      hread(9'h101, rd); chk("R10 not stalled", rd, 32'h0);

      // R9 host entry access
      hwrite(9'h008, 32'h0000_000F);
      hread(9'h008, rd); chk("R9 entry write", rd, 32'h0000_000F);

      // R3 stall on a non-empty entry
      send_frame(3, 8'hA0); send_frame(3, 8'hA1); send_frame(3, 8'hA2);
      tick(3);
      hread(9'h101, rd); chk("R3 stalled", rd, 32'h1);
      chk("R3 cur held", 32'(cur_ptr), 32'd8);
      hread(9'h008, rd); chk("R3 entry untouched", rd, 32'h0000_000F);
      hread(9'h007, rd); chk("R3 prior entry", rd, 32'h0003_A104);
      hread(9'h100, rd); chk("R3 irq", rd, 32'h7);

      // R4 staging store fills while stalled, then discards
      send_frame(3, 8'hA3); send_frame(3, 8'hA4); send_frame(3, 8'hA5);
      tick(2);
      hread(9'h100, rd); chk("R4 store-full irq", rd, 32'hF);
      hread(9'h103, rd); chk("R4 no discard yet", rd, 32'h0);
      send_frame(3, 8'hA6); send_frame(3, 8'hA7);
      tick(2);
      hread(9'h103, rd); chk("R4 discard count", rd, 32'h2);
      chk("R4 still stalled", 32'(halted), 32'h1);

      // R5 restart skips the faulting entry
      hwrite(9'h008, 32'h0000_000A);
      hwrite(9'h101, 32'h1);
      tick(8);
      hread(9'h101, rd); chk("R5 running", rd, 32'h0);
      chk("R5 cur", 32'(cur_ptr), 32'd13);
      hread(9'h008, rd); chk("R5 skipped entry", rd, 32'h0000_000A);
      hread(9'h009, rd); chk("R5 first staged", rd, 32'h0003_A204);
      hread(9'h00C, rd); chk("R5 last staged", rd, 32'h0003_A504);
      hread(9'h00D, rd); chk("R5 discarded not stored", rd, 32'h0000_000A);

      // R2 wrap across the ring end
      for (int k = 0; k < 243; k++) send_frame(1, 8'(k));
      tick(3);
      chk("R2 wrap cur", 32'(cur_ptr), 32'd0);
      chk("R2 wrap next", 32'(next_ptr), 32'd1);
      hread(9'h0FF, rd); chk("R2 entry 255", rd, 32'h0001_F204);
      chk("R6 total pulses", 32'(pulses), 32'd255);
      chk("R3 no stall without frame", 32'(halted), 32'h0);
      send_frame(1, 8'hEE);
      tick(3);
      chk("R3 stall at wrapped full entry", 32'(halted), 32'h1);
      chk("R3 cur stays 0", 32'(cur_ptr), 32'd0);

      finish_run();
   end
endmodule